// File: doc/BRIEF.md
# Lockable Clock Frequency Range Checker

This block checks that a monitored clock runs inside a programmed frequency window. The monitored clock shows up as a one-cycle edge pulse that is already synchronized to the system clock. A reference clock-enable tick sets the pace of a fixed measurement window. When a window closes, the number of monitored edges counted during it is compared with a programmable low threshold and a programmable high threshold. A count outside that range sets a sticky measurement error. A window with no monitored edge at all sets a separate sticky timeout error instead.

Software uses a small word-wide register port to set up the block. The port carries a lock flag, a 4-bit multi-bit enable code, a packed threshold word and the error word. The enable only counts as on for one exact code, so a single flipped bit disables measurement and cannot enable it. Software can clear the lock flag, but it cannot set it again. Once the flag is clear, the enable and the thresholds are frozen until reset, while the error flags can still be cleared.

Top module: `clk_range_monitor`

## Requirements
- R1: After reset, register 0 reads 0x1, register 1 reads 0x9, register 2 reads 0xEC8A and register 3 reads 0x0, and both error outputs are low.
- R2: The register port uses a 2-bit address.
  - Address 0 is the lock flag in bit 0.
  - Address 1 is the enable code in bits 3:0.
  - Address 2 holds the high threshold in bits 8:0 and the low threshold in bits 17:9.
  - Address 3 holds the measurement error in bit 0 and the timeout error in bit 1.
  - Reads are combinational, and unused bits read 0.
- R3: Measurement runs only while the enable code equals 0x9. With any other code the counters are held at zero and no error is raised.
- R4: A window lasts WIN_TICKS cycles in which ref_tick is high, counted from the cycle after enabling. Cycles with ref_tick low do not advance the window.
- R5: A window is judged in the cycle in which it closes, and any error shows on the ports one cycle later.
  - A nonzero edge count from low to high inclusive raises no error.
  - A nonzero count below low or above high sets the measurement error (bit 0).
- R6: A window with zero monitored edges sets the timeout error (bit 1) and not the measurement error.
- R7: Error bits are sticky. Writing 1 to a bit of address 3 clears only that bit, and writing 0 leaves it unchanged. A new error in the same cycle as a clear wins.
- R8: Writing 0 to bit 0 of address 0 clears the lock flag, and writing 1 never sets it again. While the flag is 0, writes to addresses 1 and 2 are ignored, but error clears still work.
- R9: meas_err_o and tmo_err_o always equal bits 0 and 1 of the error register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ref_tick | input | 1 | Reference clock-enable tick that paces the window |
| mon_edge | input | 1 | One pulse per monitored-clock edge |
| meas_err_o | output | 1 | Sticky out-of-range error |
| tmo_err_o | output | 1 | Sticky no-edge timeout error |

## Verification
The assertions check several properties on every cycle:
- the lock flag never returns to 1 after it is cleared;
- the enable and thresholds never change while the flag is clear;
- an error bit never drops without a matching write-one;
- a new error always reaches the register;
- timeout and range errors never fire for the same window;
- no error is raised while the enable code is off.

Only the bench scenarios can show the numeric behaviour:
- the exact window length, measured in ticks;
- inclusive range boundaries at both thresholds;
- the effect of gaps in ref_tick;
- the exact reset values and field positions;
- that an invalid enable code silences a window with no edges.

// File: rtl/clkmon_pkg.sv
// Shared definitions for the clock range checker: register addresses and
// error-bit indices. Assumes a 2-bit word address on the register port.
package clkmon_pkg;
    typedef enum logic [1:0] {
        ADDR_LOCK = 2'd0,
        ADDR_EN   = 2'd1,
        ADDR_CFG  = 2'd2,
        ADDR_ERR  = 2'd3
    } clkmon_addr_e;

    localparam int ERR_MEAS = 0;
    localparam int ERR_TMO  = 1;
    localparam int N_ERR    = 2;
endpackage

// File: rtl/clkmon_regs.sv
// Register file of the range checker: lock flag, enable code, threshold
// word and sticky error flags. Assumes 2*TH_W <= 32 and EN_W <= 32.
module clkmon_regs
    import clkmon_pkg::*;
#(
    parameter int           TH_W   = 9,
    parameter int           EN_W   = 4,
    parameter logic [EN_W-1:0] EN_RST = 4'h9,
    parameter logic [TH_W-1:0] HI_RST = 9'h08A,
    parameter logic [TH_W-1:0] LO_RST = 9'h076
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    input  logic [N_ERR-1:0]  set_i,
    output logic [31:0]       rdata,
    output logic              lock_o,
    output logic [EN_W-1:0]   en_o,
    output logic [2*TH_W-1:0] cfg_o,
    output logic [N_ERR-1:0]  err_o
);
    localparam int CFG_W = 2 * TH_W;

    logic wr_lock, wr_en, wr_cfg, wr_err;

    // Decode the write strobe per register.
    always_comb begin
        wr_lock = we && (addr == ADDR_LOCK);
        wr_en   = we && (addr == ADDR_EN);
        wr_cfg  = we && (addr == ADDR_CFG);
        wr_err  = we && (addr == ADDR_ERR);
    end

    // Lock flag: only ever cleared by software, restored by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                   lock_o <= 1'b1;
        else if (wr_lock && !wdata[0]) lock_o <= 1'b0;
    end

    // Enable code, writable only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)                 en_o <= EN_RST;
        else if (wr_en && lock_o)   en_o <= wdata[EN_W-1:0];
    end

    // Threshold word {low, high}, writable only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cfg_o <= {LO_RST, HI_RST};
        else if (wr_cfg && lock_o)  cfg_o <= wdata[CFG_W-1:0];
    end

    // Sticky error flags, one per bit; a set beats a write-one clear.
    for (genvar g = 0; g < N_ERR; g++) begin : g_err
        always_ff @(posedge clk) begin
            if (!rst_n) err_o[g] <= 1'b0;
            else        err_o[g] <= set_i[g] | (err_o[g] & ~(wr_err & wdata[g]));
        end
    end

    // Combinational read mux; unused bits are zero.
    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_LOCK: rdata[0]            = lock_o;
            ADDR_EN:   rdata[EN_W-1:0]     = en_o;
            ADDR_CFG:  rdata[CFG_W-1:0]    = cfg_o;
            ADDR_ERR:  rdata[N_ERR-1:0]    = err_o;
            default:   rdata               = '0;
        endcase
    end
endmodule

// File: rtl/clkmon_window.sv
// Measurement window: counts reference ticks up to WIN_TICKS and monitored
// edges in parallel while run is high. It pulses done in the closing tick
// and presents the count including that cycle's edge. Assumes
// WIN_TICKS >= 1. The edge count saturates at its maximum.
module clkmon_window #(
    parameter int WIN_TICKS = 128,
    parameter int CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ref_tick,
    input  logic             mon_edge,
    output logic             done,
    output logic [CNT_W-1:0] count
);
    localparam int TW = $clog2(WIN_TICKS + 1);
    localparam logic [TW-1:0]    LAST_TICK = TW'(WIN_TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    logic [TW-1:0]    tick_q;
    logic [CNT_W-1:0] edge_q;

    // Next edge count with saturation, and end-of-window detection.
    always_comb begin
        count = (edge_q == CNT_MAX) ? edge_q : edge_q + CNT_W'(mon_edge);
        done  = run && ref_tick && (tick_q == LAST_TICK);
    end

    // Advance both counters while running; restart after each window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) begin
            tick_q <= '0;
            edge_q <= '0;
        end else begin
            tick_q <= tick_q + TW'(ref_tick);
            edge_q <= count;
        end
    end
endmodule

// File: rtl/clkmon_judge.sv
// Window verdict: at the closing tick, flags a timeout for a zero count or
// a range error for a nonzero count outside [low, high]. Pure logic; assumes
// CNT_W > TH_W so thresholds zero-extend into the count width.
module clkmon_judge
    import clkmon_pkg::*;
#(
    parameter int TH_W  = 9,
    parameter int CNT_W = 10
) (
    input  logic             done,
    input  logic [CNT_W-1:0] count,
    input  logic [TH_W-1:0]  lo,
    input  logic [TH_W-1:0]  hi,
    output logic [N_ERR-1:0] set_o
);
    logic none, below, above;

    // Classify the finished count against both thresholds.
    always_comb begin
        none  = (count == '0);
        below = count < CNT_W'(lo);
        above = count > CNT_W'(hi);
        set_o = '0;
        set_o[ERR_TMO]  = done && none;
        set_o[ERR_MEAS] = done && !none && (below || above);
    end
endmodule

// File: rtl/clk_range_monitor.sv
// Top of the lockable clock frequency range checker. Assumes ref_tick and
// mon_edge are already synchronous single-cycle pulses in the clk domain.
module clk_range_monitor
    import clkmon_pkg::*;
#(
    parameter int              WIN_TICKS = 128,
    parameter int              TH_W      = 9,
    parameter int              EN_W      = 4,
    parameter logic [EN_W-1:0] EN_ON     = 4'h9,
    parameter logic [TH_W-1:0] HI_RST    = 9'h08A,
    parameter logic [TH_W-1:0] LO_RST    = 9'h076
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ref_tick,
    input  logic        mon_edge,
    output logic        meas_err_o,
    output logic        tmo_err_o
);
    localparam int CNT_W = TH_W + 1;

    logic              lock_q;
    logic [EN_W-1:0]   en_q;
    logic [2*TH_W-1:0] cfg_q;
    logic [N_ERR-1:0]  err_q;
    logic [N_ERR-1:0]  err_set;
    logic              run;
    logic              win_done;
    logic [CNT_W-1:0]  win_count;

    // Measurement is on only for the exact enable code.
    always_comb run = (en_q == EN_ON);

    clkmon_regs #(
        .TH_W(TH_W), .EN_W(EN_W), .EN_RST(EN_ON),
        .HI_RST(HI_RST), .LO_RST(LO_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .set_i(err_set), .rdata(reg_rdata),
        .lock_o(lock_q), .en_o(en_q), .cfg_o(cfg_q), .err_o(err_q)
    );

    clkmon_window #(.WIN_TICKS(WIN_TICKS), .CNT_W(CNT_W)) u_win (
        .clk(clk), .rst_n(rst_n), .run(run), .ref_tick(ref_tick),
        .mon_edge(mon_edge), .done(win_done), .count(win_count)
    );

    clkmon_judge #(.TH_W(TH_W), .CNT_W(CNT_W)) u_judge (
        .done(win_done), .count(win_count),
        .lo(cfg_q[2*TH_W-1:TH_W]), .hi(cfg_q[TH_W-1:0]), .set_o(err_set)
    );

    // Error outputs mirror the sticky register.
    always_comb begin
        meas_err_o = err_q[ERR_MEAS];
        tmo_err_o  = err_q[ERR_TMO];
    end
endmodule

// File: rtl/clkmon_chk.sv
// Assertion checker for clk_range_monitor, attached by bind below.
// Observes register state and the per-window error set pulses.
module clkmon_chk #(
    parameter int EN_W  = 4,
    parameter int CFG_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             lock_q,
    input logic [EN_W-1:0]  en_q,
    input logic [CFG_W-1:0] cfg_q,
    input logic [1:0]       err_q,
    input logic [1:0]       err_set,
    input logic             run
);
    assert_lock_stays_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> !lock_q);

    assert_locked_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> $stable(en_q) && $stable(cfg_q));

    assert_meas_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q[0] && !(reg_we && reg_addr == 2'd3 && reg_wdata[0]) |=> err_q[0]);

    assert_tmo_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q[1] && !(reg_we && reg_addr == 2'd3 && reg_wdata[1]) |=> err_q[1]);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_set[0] |=> err_q[0]);

    assert_tmo_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_set[0] && err_set[1]));

    assert_idle_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> err_set == 2'b00);
endmodule

bind clk_range_monitor clkmon_chk #(.EN_W(EN_W), .CFG_W(2*TH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .lock_q(lock_q), .en_q(en_q), .cfg_q(cfg_q),
    .err_q(err_q), .err_set(err_set), .run(run)
);

// File: tb/clk_range_monitor_tb.sv
module clk_range_monitor_tb;
    localparam int WIN = 128;
    localparam int NV  = 9;
    // Vector table: low, high, edges in window, expected meas, expected tmo.
    localparam int V_LO [NV] = '{118, 118, 118, 118, 100, 100, 118, 10, 10};
    localparam int V_HI [NV] = '{138, 138, 138, 138, 120, 120, 138, 20, 20};
    localparam int V_N  [NV] = '{128, 118, 117, 128, 120, 121,   0, 15,  5};
    localparam int V_EM [NV] = '{  0,   0,   1,   0,   0,   1,   0,  0,  1};
    localparam int V_ET [NV] = '{  0,   0,   0,   0,   0,   0,   1,  0,  0};

    logic        clk = 0, rst_n = 0, reg_we = 0, ref_tick = 1, mon_edge = 0;
    logic [1:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        meas_err_o, tmo_err_o;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    clk_range_monitor #(.WIN_TICKS(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ref_tick(ref_tick),
        .mon_edge(mon_edge), .meas_err_o(meas_err_o), .tmo_err_o(tmo_err_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Enable, then run one window with n edges at its start; half paces ticks.
    task automatic run_win(int n, bit half);
        int len = half ? 2 * WIN : WIN;
        wr(2'd1, 32'h9);
        for (int i = 0; i < len + 2; i++) begin
            mon_edge = half ? 1'b1 : (i < n);
            ref_tick = half ? (i % 2 == 0) : 1'b1;
            @(negedge clk);
            if (half && i == WIN + 2) check("R4 no verdict mid window", {31'd0, meas_err_o}, 32'd0);
        end
        mon_edge = 0; ref_tick = 1;
        wr(2'd1, 32'h0);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 / R2: reset values and field layout
        rd(2'd0, d); check("R1 lock reset", d, 32'h1);
        rd(2'd1, d); check("R1 enable reset", d, 32'h9);
        rd(2'd2, d); check("R1 R2 cfg reset", d, 32'hEC8A);
        rd(2'd3, d); check("R1 err reset", d, 32'h0);
        check("R9 outputs reset", {30'd0, tmo_err_o, meas_err_o}, 32'd0);

        wr(2'd1, 32'h0);
        for (int v = 0; v < NV; v++) begin
            wr(2'd2, (V_LO[v] << 9) | V_HI[v]);
            wr(2'd3, 32'h3);
            run_win(V_N[v], 1'b0);
            rd(2'd3, d);
            check("R5 R6 vector err reg", d, (V_ET[v] << 1) | V_EM[v]);
            check("R9 outputs", {30'd0, tmo_err_o, meas_err_o}, (V_ET[v] << 1) | V_EM[v]);
        end

        // R4: ref_tick at half rate doubles the window -> 256 edges, too many
        wr(2'd2, 32'hEC8A); wr(2'd3, 32'h3);
        run_win(0, 1'b1);
        rd(2'd3, d); check("R4 half-rate window", d, 32'h1);

        // R3: invalid enable code, no edges -> no timeout
        wr(2'd3, 32'h3);
        wr(2'd1, 32'hA);
        repeat (WIN + 4) @(negedge clk);
        rd(2'd3, d); check("R3 disabled code silent", d, 32'h0);
        wr(2'd1, 32'h0);

        // R7: build both errors, clear one bit at a time
        run_win(0, 1'b0);
        run_win(1, 1'b0);
        rd(2'd3, d); check("R7 sticky both", d, 32'h3);
        wr(2'd3, 32'h1);
        rd(2'd3, d); check("R7 w1c bit0 only", d, 32'h2);
        wr(2'd3, 32'h0);
        rd(2'd3, d); check("R7 write zero keeps", d, 32'h2);

        // R8: lock behaviour
        wr(2'd0, 32'h0);
        rd(2'd0, d); check("R8 lock cleared", d, 32'h0);
        wr(2'd0, 32'h1);
        rd(2'd0, d); check("R8 lock not restored", d, 32'h0);
        wr(2'd1, 32'h9);
        rd(2'd1, d); check("R8 enable frozen", d, 32'h0);
        wr(2'd2, 32'h1234);
        rd(2'd2, d); check("R8 cfg frozen", d, 32'hEC8A);
        wr(2'd3, 32'h2);
        rd(2'd3, d); check("R8 err clear while locked", d, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule